// File: doc/BRIEF.md
# Packed Byte-Average and Float-Compare Unit

This block is a 64-bit SIMD execution slice. It takes two packed operands and an 8-bit operation suffix. It returns one packed result at a fixed two-clock latency. It supports two families of operation.

The first family is a rounded-up unsigned average taken independently in each of the eight byte lanes. The second family is a single-precision floating-point comparison in each of the two 32-bit lanes. The comparison can test equal, greater-or-equal or greater-than. Each comparison lane returns a full mask of ones or zeros, which a later select or logic step can consume directly.

A separate state-exit command loads a 16-bit tag word with all ones. An unknown suffix is flagged as illegal and returns zero, at the same moment its result strobe appears.

Operand fetch, addressing and writeback lie outside the block. The surrounding pipeline presents operands with a valid strobe and picks up the result when the output strobe is high.

Top module: `simd_avgcmp`

## Requirements
- R1: In the cycle after a clock edge with `rst` high, `out_valid`, `out_illegal`, `out_data` and `tag_word` are all zero.
- R2: `out_valid` is high exactly when `in_valid` was high at the clock edge two edges earlier. Back-to-back requests and gaps are both preserved.
- R3: Suffix 0xBF gives, in every byte lane i (bits 8i+7..8i), the value (a + b + 1) >> 1 of the unsigned lane values, computed without losing the carry. Here `src_a` is a and `src_b` is b.
- R4: Suffix 0xB0 compares the low half (bits 31..0) and the high half (bits 63..32) independently as single-precision values. A value has its sign in bit 31, its exponent in bits 30..23 and its fraction in bits 22..0. A lane gives 0xFFFFFFFF when the `src_a` lane equals the `src_b` lane, and 0x00000000 otherwise.
- R5: Suffix 0x90 gives a full-ones lane when the `src_a` lane is greater than or equal to the `src_b` lane, and zero otherwise.
- R6: Suffix 0xA0 gives a full-ones lane when the `src_a` lane is strictly greater than the `src_b` lane, and zero otherwise.
- R7: +0 and -0 compare as equal. Any value whose exponent field is zero is treated as a zero of its sign.
- R8: If either operand lane is a NaN (exponent 0xFF with a nonzero fraction), every compare suffix returns zero for that lane. Infinities order normally.
- R9: Any suffix other than 0xBF, 0xB0, 0x90 and 0xA0 gives `out_data` zero with `out_illegal` high in the same cycle as `out_valid`. `out_illegal` is low at all other times.
- R10: A clock edge with `exit_req` high sets `tag_word` to 0xFFFF from the next cycle on. No other input changes `tag_word`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation request strobe |
| op_code | input | 8 | Operation suffix |
| src_a | input | 64 | First (left-hand) packed operand |
| src_b | input | 64 | Second (right-hand) packed operand |
| exit_req | input | 1 | State-exit command: loads the tag word with ones |
| out_valid | output | 1 | Result strobe, two edges after `in_valid` |
| out_data | output | 64 | Packed result |
| out_illegal | output | 1 | Unknown suffix flag, aligned with `out_valid` |
| tag_word | output | 16 | Tag word |

## Verification
An arithmetic result is due two rising edges after the edge that samples its request. The bench keeps a two-deep queue of expected results. It captures each request at the falling edge after it is driven, then checks the queue head against the outputs at the falling edge two cycles later. On that same falling edge it also checks that `out_valid` and `out_illegal` match the queue, including during idle gaps. The tag word changes one edge after `exit_req` is sampled, so it is checked at the falling edge that follows that edge.

// File: rtl/avgcmp_pkg.sv
package avgcmp_pkg;

  localparam logic [7:0] SUF_AVG = 8'hBF;
  localparam logic [7:0] SUF_CEQ = 8'hB0;
  localparam logic [7:0] SUF_CGE = 8'h90;
  localparam logic [7:0] SUF_CGT = 8'hA0;

  typedef enum logic [2:0] {
    OP_AVG,
    OP_CEQ,
    OP_CGE,
    OP_CGT,
    OP_BAD
  } op_e;

  function automatic op_e decode_suffix(input logic [7:0] suf);
    op_e r;
    case (suf)
      SUF_AVG: r = OP_AVG;
      SUF_CEQ: r = OP_CEQ;
      SUF_CGE: r = OP_CGE;
      SUF_CGT: r = OP_CGT;
      default: r = OP_BAD;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/avg_lanes.sv
module avg_lanes #(
  parameter int DATA_W = 64,
  parameter int LANE_W = 8
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [DATA_W-1:0] y
);
  localparam int LANES = DATA_W / LANE_W;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [LANE_W:0] sum;
    // widened by one bit so the carry survives the rounding add
    assign sum = {1'b0, a[i*LANE_W +: LANE_W]} + {1'b0, b[i*LANE_W +: LANE_W]}
               + {{LANE_W{1'b0}}, 1'b1};
    assign y[i*LANE_W +: LANE_W] = sum[LANE_W:1];
  end
endmodule

// File: rtl/fcmp_lane.sv
module fcmp_lane #(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23
) (
  input  logic [EXP_W+MAN_W:0] a,
  input  logic [EXP_W+MAN_W:0] b,
  output logic                 eq,
  output logic                 gt
);
  localparam int W = EXP_W + MAN_W + 1;

  logic nan_a, nan_b, zer_a, zer_b, unord;
  logic [W-2:0] mag_a, mag_b;
  logic signed [W:0] key_a, key_b;

  assign nan_a = (&a[W-2:MAN_W]) && (|a[MAN_W-1:0]);
  assign nan_b = (&b[W-2:MAN_W]) && (|b[MAN_W-1:0]);
  assign zer_a = ~|a[W-2:MAN_W];
  assign zer_b = ~|b[W-2:MAN_W];
  assign unord = nan_a | nan_b;

  // flushed magnitude, then signed key: sign-magnitude maps to two's complement
  assign mag_a = zer_a ? '0 : a[W-2:0];
  assign mag_b = zer_b ? '0 : b[W-2:0];
  assign key_a = a[W-1] ? -$signed({2'b00, mag_a}) : $signed({2'b00, mag_a});
  assign key_b = b[W-1] ? -$signed({2'b00, mag_b}) : $signed({2'b00, mag_b});

  assign eq = !unord && (key_a == key_b);
  assign gt = !unord && (key_a > key_b);
endmodule

// File: rtl/simd_avgcmp.sv
module simd_avgcmp
  import avgcmp_pkg::*;
#(
  parameter int DATA_W  = 64,
  parameter int BYTE_W  = 8,
  parameter int FLT_W   = 32,
  parameter int EXP_W   = 8,
  parameter int TAG_W   = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [7:0]        op_code,
  input  logic [DATA_W-1:0] src_a,
  input  logic [DATA_W-1:0] src_b,
  input  logic              exit_req,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic              out_illegal,
  output logic [TAG_W-1:0]  tag_word
);
  localparam int FLANES = DATA_W / FLT_W;
  localparam int MAN_W  = FLT_W - 1 - EXP_W;

  // stage 1: capture and decode
  logic              s1_valid;
  op_e               s1_op;
  logic [DATA_W-1:0] s1_a, s1_b;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid <= 1'b0;
      s1_op    <= OP_BAD;
      s1_a     <= '0;
      s1_b     <= '0;
    end else begin
      s1_valid <= in_valid;
      s1_op    <= decode_suffix(op_code);
      s1_a     <= src_a;
      s1_b     <= src_b;
    end
  end

  // stage 2 datapath
  logic [DATA_W-1:0] avg_y;
  logic [FLANES-1:0] c_eq, c_gt;
  logic [DATA_W-1:0] res;

  avg_lanes #(.DATA_W(DATA_W), .LANE_W(BYTE_W)) u_avg (
    .a(s1_a), .b(s1_b), .y(avg_y)
  );

  for (genvar l = 0; l < FLANES; l++) begin : g_fl
    fcmp_lane #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_cmp (
      .a (s1_a[l*FLT_W +: FLT_W]),
      .b (s1_b[l*FLT_W +: FLT_W]),
      .eq(c_eq[l]),
      .gt(c_gt[l])
    );
  end

  always_comb begin
    res = '0;
    case (s1_op)
      OP_AVG: res = avg_y;
      OP_CEQ: for (int l = 0; l < FLANES; l++) res[l*FLT_W +: FLT_W] = {FLT_W{c_eq[l]}};
      OP_CGE: for (int l = 0; l < FLANES; l++) res[l*FLT_W +: FLT_W] = {FLT_W{c_eq[l] | c_gt[l]}};
      OP_CGT: for (int l = 0; l < FLANES; l++) res[l*FLT_W +: FLT_W] = {FLT_W{c_gt[l]}};
      default: res = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= 1'b0;
      out_data    <= '0;
      out_illegal <= 1'b0;
    end else begin
      out_valid   <= s1_valid;
      out_data    <= res;
      out_illegal <= s1_valid && (s1_op == OP_BAD);
    end
  end

  // tag word: only the state-exit command touches it
  always_ff @(posedge clk) begin
    if (rst)           tag_word <= '0;
    else if (exit_req) tag_word <= '1;
  end
endmodule

// File: rtl/avgcmp_checker.sv
module avgcmp_checker #(
  parameter int DATA_W = 64,
  parameter int FLT_W  = 32,
  parameter int TAG_W  = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [7:0]        op_code,
  input logic              exit_req,
  input logic              out_valid,
  input logic [DATA_W-1:0] out_data,
  input logic              out_illegal,
  input logic [TAG_W-1:0]  tag_word
);
  // R2: a request yields a strobe two edges later
  a_r2_latency: assert property (@(posedge clk) disable iff (rst)
    in_valid |-> ##2 out_valid);

  // R9: illegal flag only rides on a result strobe
  a_r9_flag_with_valid: assert property (@(posedge clk) disable iff (rst)
    out_illegal |-> out_valid);

  // R9: illegal result is zero
  a_r9_zero_result: assert property (@(posedge clk) disable iff (rst)
    out_illegal |-> (out_data == '0));

  // R4: compare lanes are pure masks
  a_r4_lane_mask: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_illegal && $past(op_code, 2) != 8'hBF) |->
      ((out_data[FLT_W-1:0] == '0 || out_data[FLT_W-1:0] == '1) &&
       (out_data[DATA_W-1:FLT_W] == '0 || out_data[DATA_W-1:FLT_W] == '1)));

  // R10: exit command loads ones
  a_r10_tag_set: assert property (@(posedge clk) disable iff (rst)
    exit_req |=> (tag_word == '1));

  // R10: nothing else moves the tag word
  a_r10_tag_hold: assert property (@(posedge clk) disable iff (rst)
    !exit_req |=> $stable(tag_word));
endmodule

bind simd_avgcmp avgcmp_checker #(.DATA_W(DATA_W), .FLT_W(FLT_W), .TAG_W(TAG_W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .op_code(op_code),
  .exit_req(exit_req), .out_valid(out_valid), .out_data(out_data),
  .out_illegal(out_illegal), .tag_word(tag_word)
);

// File: tb/simd_avgcmp_bench.sv
module simd_avgcmp_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [7:0]  op_code = 8'h00;
  logic [63:0] src_a = '0, src_b = '0;
  logic        exit_req = 1'b0;
  logic        out_valid, out_illegal;
  logic [63:0] out_data;
  logic [15:0] tag_word;

  int n_checks = 0;
  int n_fail   = 0;
  string cur_tag = "R2";

  always #5 clk = ~clk;

  simd_avgcmp u_simd_avgcmp (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op_code(op_code),
    .src_a(src_a), .src_b(src_b), .exit_req(exit_req),
    .out_valid(out_valid), .out_data(out_data),
    .out_illegal(out_illegal), .tag_word(tag_word)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // ---- reference model ----
  function automatic bit is_nan(input logic [31:0] x);
    return (x[30:23] == 8'hFF) && (x[22:0] != 0);
  endfunction

  // returns {gt, eq}
  function automatic logic [1:0] fref(input logic [31:0] a, input logic [31:0] b);
    bit za, zb, am;
    za = (a[30:23] == 0);
    zb = (b[30:23] == 0);
    if (is_nan(a) || is_nan(b)) return 2'b00;
    if (za && zb) return 2'b01;
    if (za) return {b[31], 1'b0};
    if (zb) return {~a[31], 1'b0};
    if (a[31] != b[31]) return {~a[31], 1'b0};
    if (a == b) return 2'b01;
    am = (a[30:0] > b[30:0]);
    return {a[31] ? ~am : am, 1'b0};
  endfunction

  function automatic logic [63:0] model(input logic [7:0] op, input logic [63:0] a,
                                        input logic [63:0] b);
    logic [63:0] r = '0;
    logic [1:0] c;
    if (op == 8'hBF) begin
      for (int i = 0; i < 8; i++)
        r[i*8 +: 8] = 8'((int'(a[i*8 +: 8]) + int'(b[i*8 +: 8]) + 1) / 2);
    end else if (op == 8'hB0 || op == 8'h90 || op == 8'hA0) begin
      for (int l = 0; l < 2; l++) begin
        c = fref(a[l*32 +: 32], b[l*32 +: 32]);
        if ((op == 8'hB0 && c[0]) || (op == 8'h90 && (c[0] || c[1])) || (op == 8'hA0 && c[1]))
          r[l*32 +: 32] = 32'hFFFF_FFFF;
      end
    end
    return r;
  endfunction

  function automatic bit legal(input logic [7:0] op);
    return op == 8'hBF || op == 8'hB0 || op == 8'h90 || op == 8'hA0;
  endfunction

  // ---- expected-result queue, two deep ----
  bit          e1_v = 0, e2_v = 0;
  logic [63:0] e1_d = '0, e2_d = '0;
  bit          e1_i = 0, e2_i = 0;
  string       e1_t = "", e2_t = "";

  always @(negedge clk) begin
    if (rst) begin
      e1_v = 0; e2_v = 0;
    end else begin
      chk(out_valid == e2_v, "R2 out_valid", 64'(out_valid), 64'(e2_v));
      chk(out_illegal == (e2_v && e2_i), "R9 out_illegal", 64'(out_illegal), 64'(e2_v && e2_i));
      if (e2_v) chk(out_data == e2_d, e2_t, out_data, e2_d);
      e2_v = e1_v; e2_d = e1_d; e2_i = e1_i; e2_t = e1_t;
      e1_v = in_valid;
      e1_d = legal(op_code) ? model(op_code, src_a, src_b) : 64'h0;
      e1_i = !legal(op_code);
      e1_t = cur_tag;
    end
  end

  task automatic drv(input logic v, input logic [7:0] op, input logic [63:0] a,
                     input logic [63:0] b, input string tg);
    @(posedge clk); #1;
    in_valid = v; op_code = op; src_a = a; src_b = b; cur_tag = tg;
  endtask

  function automatic logic [31:0] rnd_f();
    logic [31:0] x = $urandom;
    case ($urandom % 8)
      0: x[30:0] = '0;
      1: x[30:23] = 8'h00;
      2: begin x[30:23] = 8'hFF; x[22:0] = '0; end
      3: begin x[30:23] = 8'hFF; x[22:0] = x[22:0] | 23'h1; end
      default: x[30:23] = 8'(125 + $urandom % 6);
    endcase
    return x;
  endfunction

  function automatic logic [63:0] rnd_b(input logic [63:0] a);
    logic [63:0] b;
    b = {rnd_f(), rnd_f()};
    case ($urandom % 4)
      0: b = a;
      1: b[31:0] = a[31:0] ^ 32'h8000_0000;
      default: ;
    endcase
    return b;
  endfunction

  function automatic string tag_of(input logic [7:0] op);
    case (op)
      8'hBF: return "R3 avg";
      8'hB0: return "R4 eq";
      8'h90: return "R5 ge";
      8'hA0: return "R6 gt";
      default: return "R9 illegal";
    endcase
  endfunction

  localparam logic [31:0] PZ = 32'h0000_0000, NZ = 32'h8000_0000;
  localparam logic [31:0] ONE = 32'h3F80_0000, NONE = 32'hBF80_0000;
  localparam logic [31:0] QNAN = 32'h7FC0_0000, DEN = 32'h0000_0001;
  localparam logic [31:0] PINF = 32'h7F80_0000, NINF = 32'hFF80_0000;

  initial begin
    logic [7:0] ops [4] = '{8'hBF, 8'hB0, 8'h90, 8'hA0};
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(out_valid == 0 && out_illegal == 0, "R1 strobes", {62'h0, out_valid, out_illegal}, 64'h0);
    chk(out_data == 0, "R1 data", out_data, 64'h0);
    chk(tag_word == 16'h0, "R1 tag", 64'(tag_word), 64'h0);

    // R3 sweep of every byte pair, lanes offset
    for (int a = 0; a < 256; a++)
      for (int b = 0; b < 256; b++) begin
        logic [63:0] va, vb;
        for (int i = 0; i < 8; i++) begin
          va[i*8 +: 8] = 8'(a + i * 37);
          vb[i*8 +: 8] = 8'(b + i * 91);
        end
        drv(1'b1, 8'hBF, va, vb, "R3 avg sweep");
      end

    // R7/R8 corners, every compare suffix
    for (int k = 1; k < 4; k++) begin
      drv(1'b1, ops[k], {PZ, NZ}, {NZ, PZ}, "R7 signed zeros");
      drv(1'b1, ops[k], {DEN, PZ}, {NZ, 32'h8000_1234}, "R7 denormal as zero");
      drv(1'b1, ops[k], {ONE, NONE}, {ONE, NONE}, "R4 equal values");
      drv(1'b1, ops[k], {QNAN, ONE}, {ONE, QNAN}, "R8 NaN lanes");
      drv(1'b1, ops[k], {QNAN, 32'hFF80_0001}, {QNAN, 32'hFF80_0001}, "R8 NaN self");
      drv(1'b1, ops[k], {PINF, NINF}, {ONE, NONE}, "R8 infinities order");
      drv(1'b1, ops[k], {NONE, 32'hC000_0000}, {32'hC000_0000, NONE}, "R6 negative order");
    end

    // R4..R6 random
    for (int k = 1; k < 4; k++)
      for (int n = 0; n < 3000; n++) begin
        logic [63:0] va;
        va = {rnd_f(), rnd_f()};
        drv(1'b1, ops[k], va, rnd_b(va), tag_of(ops[k]));
      end

    // R9 every suffix, with idle gaps for R2
    for (int s = 0; s < 256; s++) begin
      drv(1'b1, 8'(s), {$urandom, $urandom}, {$urandom, $urandom}, tag_of(8'(s)));
      if (s % 16 == 0) begin
        drv(1'b0, 8'(s), '0, '0, "R2 gap");
        drv(1'b0, 8'h11, '1, '1, "R2 gap");
      end
    end
    drv(1'b0, 8'h00, '0, '0, "R2 drain");
    repeat (3) @(posedge clk);

    // R10 tag word
    @(negedge clk);
    chk(tag_word == 16'h0, "R10 tag untouched by ops", 64'(tag_word), 64'h0);
    @(posedge clk); #1 exit_req = 1'b1;
    @(posedge clk); #1 exit_req = 1'b0;
    @(negedge clk);
    chk(tag_word == 16'hFFFF, "R10 tag set", 64'(tag_word), 64'hFFFF);
    drv(1'b1, 8'hB0, '0, '0, "R4 after exit");
    drv(1'b0, 8'h00, '0, '0, "R2 drain");
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(tag_word == 16'hFFFF, "R10 tag held", 64'(tag_word), 64'hFFFF);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #1_500_000;
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule